// File: doc/BRIEF.md
# Nibble Accumulator Datapath

This block holds the working state of a small 4-bit processor core and carries out one register-level micro-operation per clock. Its state is an accumulator A, a carry flag CY, a general register B and a double-width extension register E. E is loaded from, and unloaded into, the pair B:A, with B as the upper half.

The sequencer in front of the block presents an operation code with a valid strobe. It also drives a data-memory nibble and an immediate nibble. The block adds, masks, rotates or transfers and updates its registers at the next rising edge. Every register is visible on the outputs.

Reset clears A, B and CY. E has no reset value, so software must write it before it reads it. Fetch, decode, memory addressing and I/O stay outside the block.

Top module: `nib_acc_core`

## Requirements
- R1: A synchronous active-high reset clears A, B and CY to 0. E is not initialised.
- R2: When `op_valid` is low, or the code is a reserved value (12 to 15), A, B, CY and E all keep their values.
- R3: Code 0 (add memory with carry) sets A to the low 4 bits of A + memory nibble + CY. CY takes the carry out of that sum.
- R4: Code 1 (add memory) sets A to the low 4 bits of A + memory nibble. CY is unchanged.
- R5: Code 2 (add immediate) sets A to the low 4 bits of A + immediate nibble. CY is unchanged.
- R6: Code 3 (rotate right through carry) moves A bit 0 into CY and old CY into A bit 3. A bits 3..1 shift down one place.
- R7: Code 4 sets CY to 1 and code 5 clears CY to 0. A, B and E are unchanged.
- R8: Code 6 copies A into B. Code 7 copies B into A.
- R9: Code 8 loads E with B in bits 7..4 and A in bits 3..0. A and B are unchanged.
- R10: Code 9 loads B from E bits 7..4 and A from E bits 3..0. E is unchanged.
- R11: Code 10 sets A to A AND memory nibble. Code 11 sets A to A OR memory nibble. CY is unchanged for both.
- R12: CY changes only on codes 0, 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Executes `op_code` at this edge |
| op_code | input | 4 | Micro-operation select (codes in R2 to R11) |
| mem_nib | input | 4 | Data-memory nibble operand |
| imm_nib | input | 4 | Immediate nibble operand |
| acc_o | output | 4 | Accumulator A |
| cy_o | output | 1 | Carry flag CY |
| b_o | output | 4 | Register B |
| e_o | output | 8 | Register E |

## Verification
The embedded properties check these rules on every cycle:
- all state holds while no operation is valid;
- CY moves only on the four carry-affecting codes;
- the add-with-carry sum, the rotate, and the set and clear of CY;
- the exact copies between E and the pair B:A.

Other rules show only in the bench's scenarios against its cycle-level model:
- masking and the immediate add;
- the A/B copies;
- that reserved codes change nothing;
- the wrap of sums past 15 and long mixed random sequences.

E is compared only after the bench has first written it, because its reset value is undefined.

// File: rtl/nib_acc_pkg.sv
package nib_acc_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADDC = 4'd0,
    OP_ADDM = 4'd1,
    OP_ADDI = 4'd2,
    OP_RORC = 4'd3,
    OP_SETC = 4'd4,
    OP_CLRC = 4'd5,
    OP_A2B  = 4'd6,
    OP_B2A  = 4'd7,
    OP_PACK = 4'd8,
    OP_UNPK = 4'd9,
    OP_ANDM = 4'd10,
    OP_ORM  = 4'd11
  } op_e;

  function automatic logic uses_alu(input logic [OPW-1:0] op);
    return (op == OP_ADDC) || (op == OP_ADDM) || (op == OP_ADDI) ||
           (op == OP_RORC) || (op == OP_ANDM) || (op == OP_ORM);
  endfunction

  function automatic logic moves_carry(input logic [OPW-1:0] op);
    return (op == OP_ADDC) || (op == OP_RORC) ||
           (op == OP_SETC) || (op == OP_CLRC);
  endfunction
endpackage

// File: rtl/nib_acc_alu.sv
module nib_acc_alu
  import nib_acc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   m,
  input  logic [W-1:0]   imm,
  input  logic           cy,
  output logic [W-1:0]   res,
  output logic           cout
);
  logic [W-1:0] opnd;
  logic         cin;
  logic [W:0]   sum;

  always_comb begin
    opnd = (op == OP_ADDI) ? imm : m;
    cin  = (op == OP_ADDC) ? cy : 1'b0;
    sum  = {1'b0, a} + {1'b0, opnd} + {{W{1'b0}}, cin};
  end

  always_comb begin
    res  = a;
    cout = cy;
    case (op)
      OP_ADDC: begin res = sum[W-1:0]; cout = sum[W]; end
      OP_ADDM,
      OP_ADDI: res = sum[W-1:0];
      OP_RORC: begin res = {cy, a[W-1:1]}; cout = a[0]; end
      OP_ANDM: res = a & m;
      OP_ORM:  res = a | m;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/nib_acc_carry.sv
module nib_acc_carry
  import nib_acc_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           valid,
  input  logic [OPW-1:0] op,
  input  logic           a_lsb,
  input  logic           alu_cout,
  output logic           cy_q
);
  always_ff @(posedge clk) begin
    if (rst) cy_q <= 1'b0;
    else if (valid) begin
      case (op)
        OP_ADDC, OP_RORC: cy_q <= alu_cout;
        OP_SETC:          cy_q <= 1'b1;
        OP_CLRC:          cy_q <= 1'b0;
        default:          cy_q <= cy_q;
      endcase
    end
  end

  p_cy_only_four_r12: assert property (@(posedge clk) disable iff (rst)
    !(valid && moves_carry(op)) |=> $stable(cy_q));
  p_setc_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_SETC) |=> cy_q);
  p_clrc_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_CLRC) |=> !cy_q);
  p_rot_cy_r6: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_RORC) |=> cy_q == $past(a_lsb));
  p_rst_cy_r1: assert property (@(posedge clk)
    rst |=> !cy_q);
endmodule

// File: rtl/nib_acc_regs.sv
module nib_acc_regs
  import nib_acc_pkg::*;
#(
  parameter int W = 4,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [OPW-1:0]   op,
  input  logic [W-1:0]     alu_res,
  output logic [W-1:0]     a_q,
  output logic [W-1:0]     b_q,
  output logic [LANES*W-1:0] e_q
);
  localparam int EW = LANES * W;
  logic [EW-1:0] pair;
  assign pair = {b_q, a_q};

  always_ff @(posedge clk) begin
    if (rst) a_q <= '0;
    else if (valid) begin
      if (uses_alu(op))       a_q <= alu_res;
      else if (op == OP_B2A)  a_q <= b_q;
      else if (op == OP_UNPK) a_q <= e_q[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) b_q <= '0;
    else if (valid) begin
      if (op == OP_A2B)       b_q <= a_q;
      else if (op == OP_UNPK) b_q <= e_q[EW-1:EW-W];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_elane
    always_ff @(posedge clk) begin
      if (!rst && valid && op == OP_PACK) e_q[g*W +: W] <= pair[g*W +: W];
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(a_q) && $stable(b_q) && $stable(e_q)));
  p_pack_r9: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_PACK) |=> (e_q == {$past(b_q), $past(a_q)}) &&
                                 $stable(a_q) && $stable(b_q));
  p_unpk_r10: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_UNPK) |=> ({b_q, a_q} == $past(e_q)) && $stable(e_q));
  p_rst_ab_r1: assert property (@(posedge clk)
    rst |=> (a_q == '0) && (b_q == '0));
endmodule

// File: rtl/nib_acc_core.sv
module nib_acc_core
  import nib_acc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [3:0]     op_code,
  input  logic [W-1:0]   mem_nib,
  input  logic [W-1:0]   imm_nib,
  output logic [W-1:0]   acc_o,
  output logic           cy_o,
  output logic [W-1:0]   b_o,
  output logic [2*W-1:0] e_o
);
  localparam int LANES = 2;

  logic [W-1:0] alu_res;
  logic         alu_cout;

  nib_acc_alu #(.W(W)) u_alu (
    .op(op_code), .a(acc_o), .m(mem_nib), .imm(imm_nib), .cy(cy_o),
    .res(alu_res), .cout(alu_cout)
  );

  nib_acc_carry u_carry (
    .clk(clk), .rst(rst), .valid(op_valid), .op(op_code),
    .a_lsb(acc_o[0]), .alu_cout(alu_cout), .cy_q(cy_o)
  );

  nib_acc_regs #(.W(W), .LANES(LANES)) u_regs (
    .clk(clk), .rst(rst), .valid(op_valid), .op(op_code), .alu_res(alu_res),
    .a_q(acc_o), .b_q(b_o), .e_q(e_o)
  );

  p_addc_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ADDC) |=>
      {cy_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(mem_nib)} +
                        {{W{1'b0}}, $past(cy_o)}));
  p_rot_acc_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_RORC) |=>
      acc_o == {$past(cy_o), $past(acc_o[W-1:1])});
endmodule

// File: tb/nib_acc_core_bench.sv
`timescale 1ns/1ps
module nib_acc_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [3:0] mem_nib = 4'd0;
  logic [3:0] imm_nib = 4'd0;
  logic [3:0] acc_o;
  logic       cy_o;
  logic [3:0] b_o;
  logic [7:0] e_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int ma, mb, mcy, me;
  bit e_known = 0;

  always #2.5 clk = ~clk;

  nib_acc_core u_nib_acc_core (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .mem_nib(mem_nib), .imm_nib(imm_nib),
    .acc_o(acc_o), .cy_o(cy_o), .b_o(b_o), .e_o(e_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "A", int'(acc_o), ma);
    chk(tag, "B", int'(b_o), mb);
    chk(tag, "CY", int'(cy_o), mcy);
    if (e_known) chk(tag, "E", int'(e_o), me);
  endtask

  task automatic model(input bit v, input int op, input int m, input int im);
    int s;
    if (!v) return;
    case (op)
      0: begin s = ma + m + mcy; ma = s & 15; mcy = s >> 4; end
      1: ma = (ma + m) & 15;
      2: ma = (ma + im) & 15;
      3: begin s = ma & 1; ma = (mcy << 3) | (ma >> 1); mcy = s; end
      4: mcy = 1;
      5: mcy = 0;
      6: mb = ma;
      7: ma = mb;
      8: begin me = (mb << 4) | ma; e_known = 1; end
      9: begin mb = me >> 4; ma = me & 15; end
      10: ma = ma & m;
      11: ma = ma | m;
      default: ;
    endcase
  endtask

  task automatic step(input bit v, input int op, input int m, input int im, input string tag);
    op_valid = v;
    op_code  = op[3:0];
    mem_nib  = m[3:0];
    imm_nib  = im[3:0];
    model(v, op, m, im);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    op_valid = 1'b0;
    ma = 0; mb = 0; mcy = 0; e_known = 0;
    @(negedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      6, 7: return "R8";
      8: return "R9";
      9: return "R10";
      10, 11: return "R11";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R5: immediate add, wrap past 15
    step(1, 2, 0, 9, "R5");
    step(1, 2, 0, 9, "R5");
    // R3: with carry in 0, then carry out
    step(1, 0, 15, 0, "R3");
    step(1, 0, 1, 0, "R3");
    // R4 / R12: add without carry keeps CY
    step(1, 4, 0, 0, "R7");
    step(1, 1, 14, 0, "R4");
    step(1, 1, 3, 0, "R12");
    // R6: rotate several times
    step(1, 3, 0, 0, "R6");
    step(1, 3, 0, 0, "R6");
    step(1, 5, 0, 0, "R7");
    step(1, 3, 0, 0, "R6");
    // R8 transfers
    step(1, 2, 0, 6, "R5");
    step(1, 6, 0, 0, "R8");
    step(1, 2, 0, 3, "R5");
    // R9 pack, R10 unpack after disturbing A/B
    step(1, 8, 0, 0, "R9");
    step(1, 7, 0, 0, "R8");
    step(1, 2, 0, 5, "R5");
    step(1, 9, 0, 0, "R10");
    // R11 logic
    step(1, 10, 4'b0110, 0, "R11");
    step(1, 11, 4'b1001, 0, "R11");
    // R2: invalid and reserved codes change nothing
    step(0, 0, 15, 15, "R2");
    step(0, 8, 15, 15, "R2");
    step(1, 12, 15, 15, "R2");
    step(1, 15, 7, 7, "R2");
    // R1: reset mid-run
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int op;
      bit v;
      op = int'($urandom_range(0, 15));
      v  = ($urandom_range(0, 7) != 0);
      if (op == 9 && !e_known) op = 8;
      step(v, op, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
           v ? tag_of(op) : "R2");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule